// File: doc/BRIEF.md
# SPI Register Access Port

This block is a serial slave port through which a host reads and writes a bank of 64 byte-wide registers. The host frames every access with an active-low select, shifts a command byte in on MOSI most-significant bit first, and then either streams write data or chains further read addresses. SCK, select and MOSI are brought into the system clock domain through a two-flop synchronizer and edge-detected there. Inside, the port drives a plain parallel register bus (address, write data, single-cycle write strobe, single-cycle read strobe, combinational read data). A behavioural register file sits behind that bus.

The first byte of a window carries the direction in its top bit (1 for read, 0 for write) and the register address in bits 6 down to 1; bit 0 is reserved and is ignored. In a write window every complete byte after the command is written to the same register, with no address increment, so a data-port register can be filled in one burst of any length. In a read window every byte the host sends is itself the next read address. The data of the address carried by one byte comes back on MISO during the following byte. A follow-on byte of 00h closes the chain. The system clock must give at least four cycles to each SCK high and low phase, so a 10 Mbit/s link needs a system clock of at least 80 MHz.

The controller has five states. `ST_IDLE` holds while select is high. `ST_CMD` shifts in the command byte. `ST_WRITE` handles the write stream. `ST_READ` handles the chained read stream. `ST_HALT` is entered once a 00h follow-on byte arrives in a read. The transitions are: ST_IDLE to ST_CMD when select falls; ST_CMD to ST_WRITE or ST_READ when the command byte completes, chosen by its top bit; ST_READ to ST_HALT on a completed 00h byte; and any state to ST_IDLE when select rises.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, MISO is low, neither strobe is active, and register k holds the reset value 80h OR k.
- R2: The command byte is received MSB first. Bit 7 = 1 selects read and 0 selects write. Bits 6..1 give the register address. The value of bit 0 has no effect on the access.
- R3: In a write window each complete byte after the command produces exactly one write strobe carrying that byte, always to the command's address. Any number of bytes may follow, and neighbouring registers are left unchanged.
- R4: In a read window each address byte produces one read strobe. The data of that register is shifted out on MISO, MSB first, during the next byte. Every follow-on byte other than 00h is decoded as the next read address, using bits 6..1 as for the command.
- R5: A follow-on byte of 00h in a read window issues no read strobe. Afterwards, for the rest of that select window, no read strobe is issued and MISO stays low.
- R6: When select rises part-way through a byte, the partial byte is discarded and no strobe is issued. The next window starts again with a command byte.
- R7: MISO is low while select is high, during the command byte, and throughout a write window.
- R8: Each strobe lasts one system clock cycle, and the write strobe and read strobe are never active together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low select framing a window |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | output | 6 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read strobe |
| reg_rdata | output | 8 | Read data returned by the register file |

## Verification
The bench reads all 64 registers in a single chained window, both after reset and after writing every register with its own value. A port that returned data one byte early or late, or that skipped the first fall after a load, would misalign every returned byte. It sets reserved bit 0 on odd addresses, which catches a decoder that shifts the address field by one. A five-byte burst to one register is checked for strobe count and target, and the neighbouring register is read back, so an auto-incrementing port is caught. Select is dropped inside a data byte and inside a command byte, a chain is closed with 00h and more bytes are then sent, and MISO is watched after a deselect that lands on a high data bit. A port that leaked a strobe, kept reading or left MISO driven high would each fail a check.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WRITE,
        ST_READ,
        ST_HALT
    } port_state_t;

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
    parameter int              WIDTH  = 3,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= INIT;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/spi_port_regfile.sv
module spi_port_regfile #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    function automatic logic [DATA_W-1:0] seed_value(input int idx);
        logic [DATA_W-1:0] v;
        v = DATA_W'(idx);
        v[DATA_W-1] = 1'b1;
        return v;
    endfunction

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         q <= seed_value(i);
            else if (we && addr == ADDR_W'(i))  q <= wdata;
        end
        assign cells[i] = q;
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine
    import spi_port_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    output logic              miso
);

    localparam int CNT_W   = $clog2(DATA_W);
    localparam int DIR_BIT = DATA_W - 1;
    localparam int ADR_TOP = DATA_W - 2;

    port_state_t state, next_state;

    logic              sck_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              skip_fall;

    logic              rise, fall, byte_done;
    logic [DATA_W-1:0] rx_byte;

    assign rise      = sck_s & ~sck_d;
    assign fall      = ~sck_s & sck_d;
    assign rx_byte   = {rx_sh, mosi_s};
    assign byte_done = (state != ST_IDLE) && !cs_n_s && rise &&
                       (bit_cnt == CNT_W'(DATA_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:  if (!cs_n_s) next_state = ST_CMD;
            ST_CMD:   if (byte_done) next_state = rx_byte[DIR_BIT] ? ST_READ : ST_WRITE;
            ST_WRITE: next_state = ST_WRITE;
            ST_READ:  if (byte_done && rx_byte == '0) next_state = ST_HALT;
            ST_HALT:  next_state = ST_HALT;
            default:  next_state = ST_IDLE;
        endcase
        if (cs_n_s) next_state = ST_IDLE;
    end

    // shifting and bus outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d     <= 1'b0;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            skip_fall <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_we    <= 1'b0;
            bus_re    <= 1'b0;
        end else begin
            sck_d  <= sck_s;
            bus_we <= 1'b0;
            bus_re <= 1'b0;
            if (state == ST_IDLE || cs_n_s) begin
                bit_cnt   <= '0;
                tx_sh     <= '0;
                skip_fall <= 1'b0;
            end else begin
                if (rise) begin
                    rx_sh   <= rx_byte[DATA_W-2:0];
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
                if (byte_done) begin
                    if (state == ST_CMD) begin
                        bus_addr <= rx_byte[ADR_TOP -: ADDR_W];
                        bus_re   <= rx_byte[DIR_BIT];
                    end else if (state == ST_WRITE) begin
                        bus_wdata <= rx_byte;
                        bus_we    <= 1'b1;
                    end else if (state == ST_READ && rx_byte != '0) begin
                        bus_addr <= rx_byte[ADR_TOP -: ADDR_W];
                        bus_re   <= 1'b1;
                    end
                end
                if (bus_re) begin
                    tx_sh     <= rd_data;
                    skip_fall <= 1'b1;
                end else if (fall) begin
                    if (skip_fall) skip_fall <= 1'b0;
                    else           tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign miso = (state == ST_READ) ? tx_sh[DATA_W-1] : 1'b0;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re)); // R8
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> !bus_we); // R8
    AST_RE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> !bus_re); // R8
    AST_WR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && $past(state) == ST_WRITE) |-> $stable(bus_addr)); // R3
    AST_SELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> !miso); // R7
    AST_NO_STROBE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n_s) |-> !(bus_we || bus_re)); // R6
    AST_HALT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && $past(state) == ST_HALT) |-> !bus_re); // R5

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    output logic [DATA_W-1:0] reg_rdata
);

    logic [2:0] pins_s;

    spi_port_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .INIT   (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_cs_n, spi_sck, spi_mosi}),
        .dout  (pins_s)
    );

    spi_port_engine #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (pins_s[1]),
        .cs_n_s    (pins_s[2]),
        .mosi_s    (pins_s[0]),
        .rd_data   (reg_rdata),
        .bus_addr  (reg_addr),
        .bus_wdata (reg_wdata),
        .bus_we    (reg_we),
        .bus_re    (reg_re),
        .miso      (spi_miso)
    );

    spi_port_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .we    (reg_we),
        .rdata (reg_rdata)
    );

endmodule

// File: tb/spi_reg_port_test.sv
`timescale 1ns/1ps
module spi_reg_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we, reg_re;
    logic [7:0] reg_rdata;

    int total = 0;
    int bad = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    int we_addr_bad = 0;
    int strobe_bad = 0;
    logic [5:0] exp_we_addr = '0;
    logic       prev_we = 1'b0;
    logic       prev_re = 1'b0;
    logic [7:0] model [64];

    spi_reg_port uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (reg_we) begin
            we_cnt++;
            if (reg_addr !== exp_we_addr) we_addr_bad++;
        end
        if (reg_re) re_cnt++;
        if (reg_we && reg_re) strobe_bad++;
        if ((reg_we && prev_we) || (reg_re && prev_re)) strobe_bad++;
        prev_we = reg_we;
        prev_re = reg_re;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cmd(input logic rd, input int a, input logic r0);
        return {rd, 6'(a), r0};
    endfunction

    function automatic logic [7:0] wd(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            spi_mosi = tx[7-i];
            repeat (HALF) @(negedge clk);
            rx = {rx[6:0], spi_miso};
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic sel();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic desel();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic read_sweep(input string req, input logic odd_r0);
        logic [7:0] rx;
        int re0;
        re0 = re_cnt;
        sel();
        spi_byte(cmd(1'b1, 0, 1'b0), rx);
        chk({req, " miso low in command byte R7"}, rx, 8'h00);
        for (int a = 1; a < 64; a++) begin
            spi_byte(cmd(1'b1, a, odd_r0 & a[0]), rx);
            chk({req, " chained read R4"}, rx, model[a-1]);
        end
        spi_byte(8'h00, rx);
        chk({req, " last chained read R4"}, rx, model[63]);
        desel();
        chk({req, " one read strobe per address R4"}, re_cnt - re0, 64);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        int w0, r0;
        for (int a = 0; a < 64; a++) model[a] = 8'h80 | 8'(a);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 miso after reset", spi_miso, 1'b0);
        chk("R1 write strobe after reset", reg_we, 1'b0);
        chk("R1 read strobe after reset", reg_re, 1'b0);

        // R1 reset values read through a full chained sweep
        read_sweep("R1 reset values", 1'b0);

        // R2: single-byte writes to every register, reserved bit set on odd ones
        w0 = we_cnt;
        for (int a = 0; a < 64; a++) begin
            exp_we_addr = 6'(a);
            sel();
            spi_byte(cmd(1'b0, a, a[0]), rx);
            chk("R7 miso low in write command", rx, 8'h00);
            spi_byte(wd(a), rx);
            chk("R7 miso low in write data", rx, 8'h00);
            desel();
            model[a] = wd(a);
        end
        chk("R2 write strobe count", we_cnt - w0, 64);
        chk("R2 write address decode", we_addr_bad, 0);

        read_sweep("R2 readback", 1'b1);

        // R3: five-byte burst to one register, neighbour untouched
        w0 = we_cnt;
        exp_we_addr = 6'd9;
        sel();
        spi_byte(cmd(1'b0, 9, 1'b0), rx);
        for (int k = 0; k < 5; k++) begin
            spi_byte(8'(8'h3C + k * 17), rx);
            chk("R3 R7 miso low during burst", rx, 8'h00);
        end
        desel();
        model[9] = 8'(8'h3C + 4 * 17);
        chk("R3 burst strobe count", we_cnt - w0, 5);
        chk("R3 burst address fixed", we_addr_bad, 0);
        sel();
        spi_byte(cmd(1'b1, 9, 1'b0), rx);
        spi_byte(cmd(1'b1, 10, 1'b0), rx);
        chk("R3 burst final value", rx, model[9]);
        spi_byte(8'h00, rx);
        chk("R3 neighbour unchanged", rx, model[10]);
        desel();

        // R6: deselect inside a data byte
        w0 = we_cnt;
        r0 = re_cnt;
        exp_we_addr = 6'd20;
        sel();
        spi_byte(cmd(1'b0, 20, 1'b0), rx);
        spi_bits(8'hE7, 4, rx);
        desel();
        chk("R6 no write on partial byte", we_cnt - w0, 0);
        // R6: deselect inside a command byte
        sel();
        spi_bits(cmd(1'b1, 21, 1'b0), 5, rx);
        desel();
        chk("R6 no strobe on partial command", (we_cnt - w0) + (re_cnt - r0), 0);
        sel();
        spi_byte(cmd(1'b1, 20, 1'b0), rx);
        spi_byte(8'h00, rx);
        chk("R6 register kept after abort", rx, model[20]);
        desel();

        // R5: terminator ends the chain
        r0 = re_cnt;
        sel();
        spi_byte(cmd(1'b1, 5, 1'b0), rx);
        spi_byte(8'h00, rx);
        chk("R5 data before terminator", rx, model[5]);
        spi_byte(cmd(1'b1, 6, 1'b0), rx);
        chk("R5 miso low after terminator", rx, 8'h00);
        spi_byte(cmd(1'b1, 7, 1'b0), rx);
        chk("R5 miso still low", rx, 8'h00);
        desel();
        chk("R5 read strobes stop", re_cnt - r0, 1);

        // R7: deselect while a high bit is on MISO
        exp_we_addr = 6'd30;
        sel();
        spi_byte(cmd(1'b0, 30, 1'b0), rx);
        spi_byte(8'hFF, rx);
        desel();
        model[30] = 8'hFF;
        sel();
        spi_byte(cmd(1'b1, 30, 1'b0), rx);
        repeat (HALF) @(negedge clk);
        chk("R4 msb presented after command", spi_miso, 1'b1);
        spi_cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R7 miso low after deselect", spi_miso, 1'b0);
        repeat (20) @(negedge clk);
        chk("R7 miso low while idle", spi_miso, 1'b0);

        chk("R8 strobe width and exclusivity", strobe_bad, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule